// File: doc/BRIEF.md
# Two-Lane ChaCha Stream XOR Engine

This block turns a 32-bit data stream into ciphertext, or back into plaintext, by XORing each word with ChaCha keystream. It holds two block-function lanes that share the loaded key and nonce. Their block counters are one apart, so every batch yields two adjacent 64-byte keystream blocks. The buffered batch is used up strictly in order: all of the first lane's words, then all of the second lane's. To the stream this looks the same as producing one block at a time. While a batch is being consumed, the lanes already compute the next one.

A message starts with a load beat that carries a 256-bit key, a 64-bit nonce and a 64-bit starting block counter, so keystream can begin at any block position. Data beats then pass straight from the input port to the output port, XORed with the current keystream word, under valid/ready flow control. A beat with the last flag closes the message. Any keystream left over is dropped, and another load is needed before more data is taken. If the 64-bit counter would have to go past its largest value, a sticky overflow flag rises and data is refused until the next load.

Control is one state machine with four states. `S_IDLE` waits for a load. `S_WAIT` waits for both lanes to finish. `S_RUN` streams words. `S_HALT` is the overflow stop. Its transitions are:
- load: `S_IDLE` to `S_WAIT`, and `S_HALT` to `S_WAIT`.
- lanes done: `S_WAIT` to `S_RUN`.
- last beat: `S_RUN` to `S_IDLE`.
- batch drained while the lanes are still busy: `S_RUN` to `S_WAIT`.
- counter exhausted: `S_RUN` to `S_HALT`.

Top module: `chacha_x2_xor`

## Requirements
- R1: Each output word equals the input word XOR the keystream word. The keystream word is word w of ChaCha20: 20 rounds, alternating column and diagonal rounds, with the initial state added at the end. The initial state is laid out as follows:
  - words 0..3 hold the constants 0x61707865, 0x3320646e, 0x79622d32, 0x6b206574;
  - word 4+i holds ld_key[32i+31:32i];
  - word 12 holds the low counter half and word 13 the high counter half;
  - word 14 holds ld_nonce[31:0] and word 15 holds ld_nonce[63:32].
- R2: Keystream is consumed in this order: words 0 to 15 of block c, then words 0 to 15 of block c+1, then block c+2, and so on. Byte k of a word sits in data bits [8k+7:8k].
- R3: The first data word after a load uses word 0 of the block whose counter was loaded. Earlier blocks are never produced.
- R4: Adding one to the counter carries from its low 32-bit word into its high word.
- R5: Feeding ciphertext in under the same key, nonce and counter gives back the plaintext.
- R6: While out_ready is low, in_ready is low and out_valid, out_data stay held. No word is dropped or repeated.
- R7: Once the first word has been accepted, a stream with valid and ready held high moves one word every cycle, across block and batch boundaries.
- R8: After a beat with in_last is accepted, in_ready stays low and ld_ready is high until a new load.
- R9: When consumption reaches a block whose counter exceeds 2^64-1, ovf rises and stays high, and in_ready and out_valid stay low.
- R10: After reset, ld_ready=1, in_ready=0, out_valid=0 and ovf=0.
- R11: An accepted load clears ovf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load beat present |
| ld_ready | output | 1 | Load accepted (idle or halted) |
| ld_key | input | 256 | Key, word i at bits [32i+31:32i] |
| ld_nonce | input | 64 | Nonce |
| ld_ctr | input | 64 | Starting block counter |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word taken |
| in_data | input | 32 | Input word |
| in_last | input | 1 | Final word of the message |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink accepts output word |
| out_data | output | 32 | Input XOR keystream |
| out_last | output | 1 | Final word flag, passed through |
| ovf | output | 1 | Sticky counter exhaustion flag |

## Verification
Two events can fall in the same clock edge. One is the consumption of the final word of a buffered batch. The other is the batch swap: the buffer is refilled from the finished lanes, and both lanes restart on the next counter pair. The bench provokes this by streaming 96 words with no gaps and no backpressure, and by streaming 48 words under pseudo-random backpressure across a counter carry. A scoreboard of reference keystream words judges each output word, and a stall count taken after the first word must stay at zero through the swaps.

// File: rtl/chx_pkg.sv
`timescale 1ns/1ps
package chx_pkg;
    typedef logic [31:0]       word_t;
    typedef logic [15:0][31:0] blk_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
    } quad_t;

    localparam logic [3:0][31:0] SIGMA = {32'h6b206574, 32'h79622d32,
                                          32'h3320646e, 32'h61707865};

    function automatic word_t rotl(word_t v, int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    function automatic quad_t qr(quad_t q);
        quad_t r;
        r   = q;
        r.a = r.a + r.b;  r.d = rotl(r.d ^ r.a, 16);
        r.c = r.c + r.d;  r.b = rotl(r.b ^ r.c, 12);
        r.a = r.a + r.b;  r.d = rotl(r.d ^ r.a, 8);
        r.c = r.c + r.d;  r.b = rotl(r.b ^ r.c, 7);
        return r;
    endfunction

    function automatic blk_t init_state(logic [255:0] k, logic [63:0] n,
                                        logic [63:0] c);
        blk_t s;
        for (int i = 0; i < 4; i++) s[i] = SIGMA[i];
        for (int i = 0; i < 8; i++) s[4+i] = k[32*i +: 32];
        s[12] = c[31:0];
        s[13] = c[63:32];
        s[14] = n[31:0];
        s[15] = n[63:32];
        return s;
    endfunction

    function automatic blk_t blk_add(blk_t x, blk_t y);
        blk_t s;
        for (int i = 0; i < 16; i++) s[i] = x[i] + y[i];
        return s;
    endfunction
endpackage

// File: rtl/chx_round.sv
`timescale 1ns/1ps
// One ChaCha round: four quarter rounds on columns or on diagonals.
module chx_round
    import chx_pkg::*;
(
    input  blk_t x_i,
    input  logic diag_i,
    output blk_t y_o
);
    blk_t yc;
    blk_t yd;

    for (genvar g = 0; g < 4; g++) begin : g_qr
        localparam int BC = 4 + g;
        localparam int CC = 8 + g;
        localparam int DC = 12 + g;
        localparam int BD = 4 + ((g + 1) % 4);
        localparam int CD = 8 + ((g + 2) % 4);
        localparam int DD = 12 + ((g + 3) % 4);
        quad_t qc;
        quad_t qd;
        assign qc = qr({x_i[g], x_i[BC], x_i[CC], x_i[DC]});
        assign qd = qr({x_i[g], x_i[BD], x_i[CD], x_i[DD]});
        assign yc[g]  = qc.a;
        assign yc[BC] = qc.b;
        assign yc[CC] = qc.c;
        assign yc[DC] = qc.d;
        assign yd[g]  = qd.a;
        assign yd[BD] = qd.b;
        assign yd[CD] = qd.c;
        assign yd[DD] = qd.d;
    end

    assign y_o = diag_i ? yd : yc;
endmodule

// File: rtl/chx_lane.sv
`timescale 1ns/1ps
// Iterative block-function lane: one round per cycle, feed-forward add at the end.
module chx_lane
    import chx_pkg::*;
#(
    parameter int ROUNDS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  blk_t init_i,
    output logic done_o,
    output blk_t blk_o
);
    localparam int RW = $clog2(ROUNDS);

    typedef enum logic [1:0] {L_IDLE, L_RUN, L_DONE} lst_t;

    lst_t           st_q;
    logic [RW-1:0]  rnd_q;
    blk_t           x_q;
    blk_t           init_q;
    blk_t           y;

    chx_round u_round (
        .x_i   (x_q),
        .diag_i(rnd_q[0]),
        .y_o   (y)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= L_IDLE;
            rnd_q <= '0;
        end else if (start_i) begin
            st_q  <= L_RUN;
            rnd_q <= '0;
        end else begin
            unique case (st_q)
                L_RUN: begin
                    if (rnd_q == RW'(ROUNDS - 1)) st_q <= L_DONE;
                    rnd_q <= rnd_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (start_i) begin
            x_q    <= init_i;
            init_q <= init_i;
        end else if (st_q == L_RUN) begin
            x_q <= (rnd_q == RW'(ROUNDS - 1)) ? blk_add(y, init_q) : y;
        end
    end

    assign done_o = (st_q == L_DONE);
    assign blk_o  = x_q;
endmodule

// File: rtl/chacha_x2_xor.sv
`timescale 1ns/1ps
module chacha_x2_xor
    import chx_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int ROUNDS = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_valid,
    output logic         ld_ready,
    input  logic [255:0] ld_key,
    input  logic [63:0]  ld_nonce,
    input  logic [63:0]  ld_ctr,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [31:0]  in_data,
    input  logic         in_last,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [31:0]  out_data,
    output logic         out_last,
    output logic         ovf
);
    localparam int WORDS = LANES * 16;
    localparam int PW    = $clog2(WORDS);
    localparam int LW    = PW - 4;

    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN, S_HALT} st_t;

    st_t              st_q, st_d;
    logic [255:0]     key_q;
    logic [63:0]      nonce_q;
    logic [64:0]      base_q;
    logic [PW-1:0]    rptr_q;
    logic [LANES-1:0] bok_q, pend_q;
    blk_t             ks_q [LANES];

    logic [LANES-1:0] lane_done, lane_ok;
    blk_t             lane_init [LANES];
    blk_t             lane_blk  [LANES];

    logic             ld_fire, fire, wrap, all_done, swap, lane_start;
    logic             word_ok, live;
    logic [LW-1:0]    sel;
    word_t            ks_word;
    logic [255:0]     k_sel;
    logic [63:0]      n_sel;

    assign all_done = &lane_done;
    assign k_sel    = ld_fire ? ld_key : key_q;
    assign n_sel    = ld_fire ? ld_nonce : nonce_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [64:0] cnt;
        assign cnt          = (ld_fire ? {1'b0, ld_ctr} : base_q) + 65'(l);
        assign lane_ok[l]   = ~cnt[64];
        assign lane_init[l] = init_state(k_sel, n_sel, cnt[63:0]);
        chx_lane #(.ROUNDS(ROUNDS)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .start_i(lane_start),
            .init_i (lane_init[l]),
            .done_o (lane_done[l]),
            .blk_o  (lane_blk[l])
        );
    end

    // Output and handshake decode.
    always_comb begin
        sel        = rptr_q[PW-1:4];
        ks_word    = ks_q[sel][rptr_q[3:0]];
        word_ok    = bok_q[sel];
        live       = (st_q == S_RUN) && word_ok;
        ld_ready   = (st_q == S_IDLE) || (st_q == S_HALT);
        in_ready   = live && out_ready;
        out_valid  = live && in_valid;
        out_data   = in_data ^ ks_word;
        out_last   = in_last;
        ovf        = (st_q == S_HALT);
        ld_fire    = ld_valid && ld_ready;
        fire       = in_valid && in_ready;
        wrap       = fire && (rptr_q == PW'(WORDS - 1)) && !in_last;
        swap       = all_done && ((st_q == S_WAIT) || wrap);
        lane_start = ld_fire || swap;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (ld_fire) st_d = S_WAIT;
            S_WAIT: if (all_done) st_d = S_RUN;
            S_RUN: begin
                if (!word_ok)              st_d = S_HALT;
                else if (fire && in_last)  st_d = S_IDLE;
                else if (wrap && !all_done) st_d = S_WAIT;
            end
            S_HALT: if (ld_fire) st_d = S_WAIT;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q   <= '0;
            nonce_q <= '0;
            base_q  <= '0;
            rptr_q  <= '0;
            bok_q   <= '0;
            pend_q  <= '0;
        end else begin
            if (lane_start) pend_q <= lane_ok;
            if (ld_fire) begin
                key_q   <= ld_key;
                nonce_q <= ld_nonce;
                base_q  <= {1'b0, ld_ctr} + 65'(LANES);
                rptr_q  <= '0;
            end else if (swap) begin
                bok_q  <= pend_q;
                base_q <= base_q + 65'(LANES);
                rptr_q <= '0;
            end else if (fire) begin
                rptr_q <= rptr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (swap) begin
            for (int l = 0; l < LANES; l++) ks_q[l] <= lane_blk[l];
        end
    end
endmodule

// File: rtl/chacha_x2_xor_chk.sv
`timescale 1ns/1ps
module chacha_x2_xor_chk (
    input logic clk,
    input logic rst_n,
    input logic ld_valid,
    input logic ld_ready,
    input logic in_valid,
    input logic in_ready,
    input logic in_last,
    input logic out_valid,
    input logic out_ready,
    input logic ovf
);
    a_r6_ready_needs_sink: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_ready);
    a_r6_valid_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid);
    a_r9_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (!in_ready && !out_valid));
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(ld_valid && ld_ready)) |=> ovf);
    a_r11_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready) |=> !ovf);
    a_r8_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> (!in_ready && ld_ready));
endmodule

bind chacha_x2_xor chacha_x2_xor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_ready (ld_ready),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_last  (in_last),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .ovf      (ovf)
);

// File: tb/chacha_x2_xor_test.sv
`timescale 1ns/1ps
module chacha_x2_xor_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_valid = 1'b0;
    logic         ld_ready;
    logic [255:0] ld_key = '0;
    logic [63:0]  ld_nonce = '0;
    logic [63:0]  ld_ctr = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_data = '0;
    logic         in_last = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [31:0]  out_data;
    logic         out_last;
    logic         ovf;

    int n_chk = 0;
    int n_fail = 0;
    bit bp_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [32:0] expq[$];
    string       tagq[$];

    always #4 clk = ~clk;

    chacha_x2_xor uut (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_ready(ld_ready),
        .ld_key(ld_key), .ld_nonce(ld_nonce), .ld_ctr(ld_ctr),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .ovf(ovf)
    );

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference keystream, written from the requirement text.
    function automatic logic [31:0] rl(logic [31:0] v, int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    function automatic void tq(inout logic [31:0] a, inout logic [31:0] b,
                               inout logic [31:0] c, inout logic [31:0] d);
        a += b; d = rl(d ^ a, 16);
        c += d; b = rl(b ^ c, 12);
        a += b; d = rl(d ^ a, 8);
        c += d; b = rl(b ^ c, 7);
    endfunction

    function automatic logic [31:0] ref_word(logic [255:0] k, logic [63:0] n,
                                             logic [63:0] c, int idx);
        logic [31:0] s[16];
        logic [31:0] w[16];
        s[0] = 32'h61707865; s[1] = 32'h3320646e;
        s[2] = 32'h79622d32; s[3] = 32'h6b206574;
        for (int i = 0; i < 8; i++) s[4+i] = k[32*i +: 32];
        s[12] = c[31:0];  s[13] = c[63:32];
        s[14] = n[31:0];  s[15] = n[63:32];
        w = s;
        for (int r = 0; r < 10; r++) begin
            tq(w[0], w[4], w[8],  w[12]);
            tq(w[1], w[5], w[9],  w[13]);
            tq(w[2], w[6], w[10], w[14]);
            tq(w[3], w[7], w[11], w[15]);
            tq(w[0], w[5], w[10], w[15]);
            tq(w[1], w[6], w[11], w[12]);
            tq(w[2], w[7], w[8],  w[13]);
            tq(w[3], w[4], w[9],  w[14]);
        end
        return w[idx] + s[idx];
    endfunction

    function automatic logic [31:0] pword(int i, int seed);
        return (32'h9e3779b9 * (i + seed + 1)) ^ 32'h5a5a0f0f;
    endfunction

    // Sink ready pattern, changed just after each rising edge.
    initial forever begin
        @(posedge clk); #1;
        out_ready = bp_en ? lfsr[0] : 1'b1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    // Monitor: pops the scoreboard, checks hold behaviour under backpressure.
    logic        prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    initial forever begin
        @(negedge clk); #3;
        if (rst_n) begin
            if (prev_stall) begin
                chk(out_valid && out_data == prev_data, "R6 hold", {31'b0, out_valid, out_data}, {32'd1, prev_data});
            end
            if (!out_ready) chk(!in_ready, "R6 ready", in_ready, 0);
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R2 unexpected word", out_data, 0);
                end else begin
                    logic [32:0] e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    chk({out_last, out_data} == e, t, {out_last, out_data}, e);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    task automatic load(logic [255:0] k, logic [63:0] n, logic [63:0] c);
        @(negedge clk);
        ld_valid = 1'b1; ld_key = k; ld_nonce = n; ld_ctr = c;
        #3;
        chk(ld_ready, "R8 ld_ready", ld_ready, 1);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic send(logic [255:0] k, logic [63:0] n, logic [63:0] c,
                        int nw, int seed, bit cmode, bit lst, string tag,
                        output int stalls);
        stalls = 0;
        for (int i = 0; i < nw; i++) begin
            logic [31:0] ks, p;
            bit l;
            ks = ref_word(k, n, c + 64'(i / 16), i % 16);
            p  = pword(i, seed);
            l  = lst && (i == nw - 1);
            expq.push_back({l, cmode ? p : (p ^ ks)});
            tagq.push_back(tag);
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = cmode ? (p ^ ks) : p;
            in_last  = l;
            while (1) begin
                #3;
                if (in_ready) break;
                if (i > 0) stalls++;
                @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic after_last_probe();
        in_valid = 1'b1;
        in_data  = 32'hDEAD_BEEF;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk); #3;
            chk(!in_ready && !out_valid, "R8 closed after last", {in_ready, out_valid}, 0);
        end
        chk(ld_ready, "R8 ld_ready after last", ld_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int j = 0; j < 50 && expq.size() != 0; j++) @(negedge clk);
        chk(expq.size() == 0, "R2 scoreboard drained", expq.size(), 0);
    endtask

    task automatic run_all();
        logic [255:0] k1, k2;
        logic [63:0]  n1, n2;
        int st;
        k1 = {32'h1f1e1d1c, 32'h1b1a1918, 32'h17161514, 32'h13121110,
              32'h0f0e0d0c, 32'h0b0a0908, 32'h07060504, 32'h03020100};
        n1 = 64'h4a000000_09000000;
        k2 = {8{32'hc0ffee11}} ^ {256'h1234_5678_9abc};
        n2 = 64'hfeedface_0badf00d;

        // R10 reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #3;
        chk(ld_ready && !in_ready && !out_valid && !ovf, "R10 reset",
            {ld_ready, in_ready, out_valid, ovf}, 4'b1000);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R7: continuous 96-word stream from counter 0
        load(k1, n1, 64'd0);
        send(k1, n1, 64'd0, 96, 0, 1'b0, 1'b1, "R1 R2 keystream word", st);
        chk(st == 0, "R7 no bubbles", st, 0);
        drain();
        after_last_probe();

        // R4 R6: carry across low/high counter words, random backpressure
        bp_en = 1'b1;
        load(k2, n2, 64'h00000000_ffffffff);
        send(k2, n2, 64'h00000000_ffffffff, 48, 7, 1'b0, 1'b1, "R4 R6 carry word", st);
        drain();
        bp_en = 1'b0;
        @(negedge clk);

        // R3 R5: arbitrary start block, ciphertext in gives plaintext out
        load(k1, n1, 64'd5);
        send(k1, n1, 64'd5, 20, 3, 1'b1, 1'b1, "R3 R5 decrypt word", st);
        drain();
        chk(!ovf, "R9 no ovf in range", ovf, 0);

        // R9: counter at 2^64-1, second block not addressable
        load(k2, n1, 64'hffffffff_ffffffff);
        send(k2, n1, 64'hffffffff_ffffffff, 16, 11, 1'b0, 1'b0, "R9 last valid block", st);
        drain();
        in_valid = 1'b1;
        in_data  = 32'h0;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk); #3;
            chk(!in_ready && !out_valid, "R9 refuse data", {in_ready, out_valid}, 0);
        end
        chk(ovf, "R9 ovf set", ovf, 1);
        repeat (3) @(negedge clk);
        chk(ovf, "R9 ovf sticky", ovf, 1);
        in_valid = 1'b0;

        // R11 R3 R8: reload clears flag, short message ending mid block
        load(k2, n2, 64'd7);
        #3;
        chk(!ovf, "R11 ovf cleared", ovf, 0);
        send(k2, n2, 64'd7, 5, 21, 1'b0, 1'b1, "R3 R8 fresh message", st);
        drain();
        after_last_probe();
        load(k1, n2, 64'd7);
        send(k1, n2, 64'd7, 3, 30, 1'b0, 1'b1, "R3 restart at word 0", st);
        drain();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule